// File: doc/BRIEF.md
# Simple Register-Mapped Serial Port

This block is an asynchronous serial transmitter and receiver for a system bus. Software reaches it through a small register file over a valid/ready request port with a registered read response. Each direction holds exactly one byte. A byte written to the data register is framed and shifted out on the transmit line. A byte recovered from the receive line waits in the data register until software reads it. The frame format is fixed: one low start bit, eight data bits with the least significant bit first, no parity, and one high stop bit. The line is high when idle.

Bit timing comes from a 21-bit divisor. The divisor is the number of system clocks in one serial bit, and its smallest usable value is 16. The receiver waits half a divisor after a falling edge and checks that the line is still low there. After that it takes each data bit at the centre of its bit period. Four sticky event flags feed three interrupt lines: one for transmit, one for receive, and one shared by both overrun conditions. Software clears each flag by writing one to its bit.

Top module: `sbu_uart`

## Requirements
- R1: After reset, the status, control and flag registers read 0, the divisor reads 16, the transmit line is high and all three interrupt outputs are low.
- R2: A read accepted at a clock edge returns its data with `rsp_valid` high for one cycle after that edge. The byte offsets are 0x00 data, 0x04 status, 0x08 control, 0x0C flags and 0x10 divisor. Control keeps bits 5:0. The divisor keeps bits 20:0 and ignores higher bits.
- R3: A transmit frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts exactly one divisor of clocks, and the line stays high whenever no frame is in progress.
- R4: Status bit 0 (transmit full) is set by a data write. It clears on the edge where the byte moves into the shifter, which happens only while control bit 0 (transmit enable) is 1. While that bit is 0, a buffered byte stays in the buffer and the line stays idle.
- R5: A data write while transmit full is set is dropped. It sets status bit 2 (transmit overrun), and that bit stays set until software writes 1 to bit 2 of the status register.
- R6: With control bit 1 (receive enable) set, a received byte becomes readable at offset 0x00 and sets status bit 1 (receive full). Reading the data register clears receive full.
- R7: A low pulse on the receive line that is high again by half a divisor after its falling edge is rejected, and no byte is produced.
- R8: A byte that arrives while receive full is set and not being read is discarded. It sets status bit 3 (receive overrun), the buffered byte is kept, and software clears bit 3 by writing 1 to it in the status register.
- R9: Flag bit 0 is set when the transmit buffer empties into the shifter. Flag bit 1 is set when a byte lands in the receive buffer. Flag bits 2 and 3 are set by transmit and receive overrun. Writing 1 to a flag bit at offset 0x0C clears only that bit.
- R10: One cycle after the flags or the control register change, `irq_tx` equals flag 0 AND control bit 2, `irq_rx` equals flag 1 AND control bit 3, and `irq_ovr` equals (flag 2 AND control bit 4) OR (flag 3 AND control bit 5).
- R11: While receive enable is 0, activity on the receive line produces no byte and no receive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ovr | output | 1 | Combined overrun interrupt |

## Verification
A write updates registers and flags on the edge that accepts it. Read data appears on the following edge, so the bench samples it at the next falling edge. If transmit is enabled, the start bit begins one edge after the data write. The interrupt outputs follow their flag or control bit one edge later, so the bench waits two falling edges before sampling them. A scoreboard queue holds the transmitted bytes. A line monitor samples the transmit line at the centre of every bit and compares each decoded frame with the queue. Bytes sent back through loopback are checked at the register port only after a full frame time plus margin has passed.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int unsigned CHAR_W = 8;

  localparam logic [4:0] OFS_DATA = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_FLAG = 5'h0C;
  localparam logic [4:0] OFS_DIV  = 5'h10;

  // status bit positions
  localparam int ST_TXFULL = 0;
  localparam int ST_RXFULL = 1;
  localparam int ST_TXOVR  = 2;
  localparam int ST_RXOVR  = 3;

  // control bit positions
  localparam int CT_TXEN  = 0;
  localparam int CT_RXEN  = 1;
  localparam int CT_TXIE  = 2;
  localparam int CT_RXIE  = 3;
  localparam int CT_TXOIE = 4;
  localparam int CT_RXOIE = 5;
  localparam int CTRL_W   = 6;

  // flag bit positions
  localparam int FL_TX  = 0;
  localparam int FL_RX  = 1;
  localparam int FL_TXO = 2;
  localparam int FL_RXO = 3;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sbu_tx_engine.sv
module sbu_tx_engine #(
  parameter int DIV_W  = 21,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAR_W-1:0] din,
  input  logic [DIV_W-1:0]  div,
  output logic              busy,
  output logic              txd
);
  localparam int LAST  = CHAR_W + 1;
  localparam int IDX_W = $clog2(CHAR_W + 2);

  logic [DIV_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      frame <= '1;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        frame <= din;
        idx   <= '0;
        cnt   <= div - 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (idx == IDX_W'(LAST)) begin
      busy <= 1'b0;
    end else begin
      idx   <= idx + 1'b1;
      txd   <= frame[0];
      frame <= {1'b1, frame[CHAR_W-1:1]};
      cnt   <= div - 1'b1;
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R3
  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && (cnt != '0) |=> $stable(txd)); // R3
endmodule

// File: rtl/sbu_rx_engine.sv
module sbu_rx_engine
  import sbu_pkg::*;
#(
  parameter int DIV_W  = 21,
  parameter int CHAR_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  div,
  output logic              done,
  output logic [CHAR_W-1:0] dout
);
  localparam int IDX_W = $clog2(CHAR_W);

  logic [SYNC_N-1:0] sync;
  logic              rxs;
  rx_state_e         state;
  logic [DIV_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;

  generate
    if (SYNC_N > 1) begin : g_multi
      always_ff @(posedge clk)
        if (rst) sync <= '1;
        else     sync <= {sync[SYNC_N-2:0], rxd};
    end else begin : g_single
      always_ff @(posedge clk)
        if (rst) sync <= '1;
        else     sync <= rxd;
    end
  endgenerate
  assign rxs = sync[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      dout  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (!rxs) begin
            state <= RX_START;
            cnt   <= (div >> 1) - 1'b1;
          end
          RX_START: if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!rxs) begin
              state <= RX_DATA;
              idx   <= '0;
              cnt   <= div - 1'b1;
            end else state <= RX_IDLE;
          RX_DATA: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              dout <= {rxs, dout[CHAR_W-1:1]};
              cnt  <= div - 1'b1;
              idx  <= idx + 1'b1;
              if (idx == IDX_W'(CHAR_W - 1)) state <= RX_STOP;
            end
          RX_STOP: if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              done  <= rxs;
              state <= RX_IDLE;
            end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done); // R11
endmodule

// File: rtl/sbu_uart.sv
module sbu_uart
  import sbu_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 21,
  parameter int DIV_RST = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr
);
  logic              acc, wr, rd;
  logic              wr_data, wr_stat, wr_ctrl, wr_flag, wr_div, rd_data;
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  div;
  logic [CHAR_W-1:0] txbuf, rxbuf, rx_byte;
  logic              txfull, rxfull, txovr, rxovr;
  logic [FLAG_W-1:0] flag, flag_set, flag_clr;
  logic              tx_busy, tx_start, rx_done, rx_accept, tx_ovr_ev, rx_ovr_ev;

  assign req_ready = 1'b1;
  assign acc = req_valid && req_ready;
  assign wr  = acc && req_write;
  assign rd  = acc && !req_write;
  assign wr_data = wr && (req_addr == ADDR_W'(OFS_DATA));
  assign wr_stat = wr && (req_addr == ADDR_W'(OFS_STAT));
  assign wr_ctrl = wr && (req_addr == ADDR_W'(OFS_CTRL));
  assign wr_flag = wr && (req_addr == ADDR_W'(OFS_FLAG));
  assign wr_div  = wr && (req_addr == ADDR_W'(OFS_DIV));
  assign rd_data = rd && (req_addr == ADDR_W'(OFS_DATA));

  assign tx_start  = txfull && ctrl[CT_TXEN] && !tx_busy;
  assign tx_ovr_ev = wr_data && txfull;
  assign rx_accept = rx_done && (!rxfull || rd_data);
  assign rx_ovr_ev = rx_done && rxfull && !rd_data;

  always_comb begin
    flag_set         = '0;
    flag_set[FL_TX]  = tx_start;
    flag_set[FL_RX]  = rx_accept;
    flag_set[FL_TXO] = tx_ovr_ev;
    flag_set[FL_RXO] = rx_ovr_ev;
    flag_clr = wr_flag ? req_wdata[FLAG_W-1:0] : '0;
  end

  sbu_tx_engine #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .din(txbuf), .div(div),
    .busy(tx_busy), .txd(txd));

  sbu_rx_engine #(.DIV_W(DIV_W), .CHAR_W(CHAR_W), .SYNC_N(SYNC_N)) u_rx (
    .clk(clk), .rst(rst), .en(ctrl[CT_RXEN]), .rxd(rxd), .div(div),
    .done(rx_done), .dout(rx_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      div    <= DIV_W'(DIV_RST);
      txbuf  <= '0;
      txfull <= 1'b0;
      txovr  <= 1'b0;
      rxbuf  <= '0;
      rxfull <= 1'b0;
      rxovr  <= 1'b0;
      flag   <= '0;
    end else begin
      if (wr_ctrl) ctrl <= req_wdata[CTRL_W-1:0];
      if (wr_div)  div  <= req_wdata[DIV_W-1:0];

      if (wr_data && !txfull) begin
        txbuf  <= req_wdata[CHAR_W-1:0];
        txfull <= 1'b1;
      end else if (tx_start) begin
        txfull <= 1'b0;
      end

      if (tx_ovr_ev) txovr <= 1'b1;
      else if (wr_stat && req_wdata[ST_TXOVR]) txovr <= 1'b0;

      if (rx_accept) begin
        rxbuf  <= rx_byte;
        rxfull <= 1'b1;
      end else if (rd_data) begin
        rxfull <= 1'b0;
      end

      if (rx_ovr_ev) rxovr <= 1'b1;
      else if (wr_stat && req_wdata[ST_RXOVR]) rxovr <= 1'b0;

      flag <= (flag & ~flag_clr) | flag_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_ovr <= 1'b0;
    end else begin
      irq_tx  <= flag[FL_TX] && ctrl[CT_TXIE];
      irq_rx  <= flag[FL_RX] && ctrl[CT_RXIE];
      irq_ovr <= (flag[FL_TXO] && ctrl[CT_TXOIE]) || (flag[FL_RXO] && ctrl[CT_RXOIE]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= '0;
      if (rd) begin
        case (req_addr)
          ADDR_W'(OFS_DATA): rsp_rdata <= DATA_W'(rxbuf);
          ADDR_W'(OFS_STAT): rsp_rdata <= DATA_W'({rxovr, txovr, rxfull, txfull});
          ADDR_W'(OFS_CTRL): rsp_rdata <= DATA_W'(ctrl);
          ADDR_W'(OFS_FLAG): rsp_rdata <= DATA_W'(flag);
          ADDR_W'(OFS_DIV):  rsp_rdata <= DATA_W'(div);
          default:           rsp_rdata <= '0;
        endcase
      end
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid); // R2
  AST_TXFULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    txfull && !ctrl[CT_TXEN] |=> txfull); // R4
  AST_TXOVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    txovr && !(wr_stat && req_wdata[ST_TXOVR]) |=> txovr); // R5
  AST_RXBUF_KEPT: assert property (@(posedge clk) disable iff (rst)
    rxfull && !rd_data |=> $stable(rxbuf)); // R8
  AST_IRQ_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(ctrl[CT_TXIE])); // R10
endmodule

// File: tb/sbu_uart_bench.sv
module sbu_uart_bench;
  localparam int DIV   = 20;
  localparam int FRAME = 10 * DIV + 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, txd, irq_tx, irq_rx, irq_ovr;
  logic [31:0] rsp_rdata;
  logic        loop_en = 1'b1, bench_rxd = 1'b1;
  logic        rxd_w;
  int          checks = 0, errors = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] rv;
  int          cnt;

  always #10 clk = ~clk;
  assign rxd_w = loop_en ? txd : bench_rxd;

  sbu_uart u_sbu_uart (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rxd(rxd_w), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    bus_write(5'h00, {24'h0, b});
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b);
    bench_rxd = 1'b0; wait_cycles(DIV);
    for (int i = 0; i < 8; i++) begin bench_rxd = b[i]; wait_cycles(DIV); end
    bench_rxd = 1'b1; wait_cycles(DIV);
  endtask

  // line monitor: decodes frames on txd at bit centres, compares with queue
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        wait_cycles(DIV / 2);
        check("R3 start bit low", {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          wait_cycles(DIV);
          got[i] = txd;
        end
        wait_cycles(DIV);
        check("R3 stop bit high", {31'h0, txd}, 32'h1);
        if (exp_q.size() == 0) check("R3 unexpected frame", {24'h0, got}, 32'hFFFF_FFFF);
        else check("R3 frame data", {24'h0, got}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    wait_cycles(150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(5);
    rst = 1'b0;
    // R1 reset state
    check("R1 txd idle", {31'h0, txd}, 32'h1);
    check("R1 irqs", {29'h0, irq_tx, irq_rx, irq_ovr}, 32'h0);
    bus_read(5'h04, rv); check("R1 status", rv, 32'h0);
    check("R2 rsp_valid", {30'h0, rsp_valid, req_ready}, 32'h3);
    bus_read(5'h08, rv); check("R1 control", rv, 32'h0);
    bus_read(5'h0C, rv); check("R1 flags", rv, 32'h0);
    bus_read(5'h10, rv); check("R1 divisor", rv, 32'd16);
    // R2 register readback
    bus_write(5'h10, 32'hFFE0_0000 | DIV);
    bus_read(5'h10, rv); check("R2 divisor width", rv, 32'(DIV));
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, rv); check("R2 control width", rv, 32'h3F);
    bus_write(5'h08, 32'h0);
    // R4 held while disabled
    send_byte(8'h5A);
    bus_read(5'h04, rv); check("R4 full set", rv, 32'h1);
    wait_cycles(50);
    check("R4 line idle", {31'h0, txd}, 32'h1);
    bus_read(5'h04, rv); check("R4 still full", rv, 32'h1);
    bus_write(5'h08, 32'h03);
    wait_cycles(FRAME);
    bus_read(5'h04, rv); check("R6 rx full", rv, 32'h2);
    bus_read(5'h0C, rv); check("R9 tx+rx flags", rv, 32'h3);
    check("R10 masked irqs", {30'h0, irq_tx, irq_rx}, 32'h0);
    bus_write(5'h08, 32'h0F);
    wait_cycles(2);
    check("R10 enabled irqs", {30'h0, irq_tx, irq_rx}, 32'h3);
    bus_read(5'h00, rv); check("R6 data", rv, 32'h5A);
    bus_read(5'h04, rv); check("R6 full cleared", rv, 32'h0);
    bus_write(5'h0C, 32'h1);
    bus_read(5'h0C, rv); check("R9 w1c selective", rv, 32'h2);
    wait_cycles(2);
    check("R10 irq follow clear", {30'h0, irq_tx, irq_rx}, 32'h1);
    bus_write(5'h0C, 32'h2);
    // R3 start-bit length
    send_byte(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    cnt = 0;
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    check("R3 start bit length", 32'(cnt), 32'(DIV));
    wait_cycles(FRAME);
    bus_read(5'h00, rv); check("R6 data 01", rv, 32'h01);
    bus_write(5'h0C, 32'h3);
    // R5 transmit overrun: two data writes on consecutive edges
    bus_write(5'h08, 32'h3F);
    exp_q.push_back(8'hA5);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h00; req_wdata = 32'hA5;
    @(negedge clk);
    req_wdata = 32'h3C;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    wait_cycles(FRAME);
    bus_read(5'h04, rv); check("R5 tx overrun", rv, 32'h6);
    bus_read(5'h0C, rv); check("R9 overrun flag", rv, 32'h7);
    check("R10 irq_ovr", {31'h0, irq_ovr}, 32'h1);
    bus_write(5'h04, 32'h4);
    bus_read(5'h04, rv); check("R5 overrun cleared", rv, 32'h2);
    bus_read(5'h00, rv); check("R5 first byte kept", rv, 32'hA5);
    bus_write(5'h0C, 32'hF);
    wait_cycles(2);
    check("R10 irq_ovr cleared", {31'h0, irq_ovr}, 32'h0);
    bus_read(5'h0C, rv); check("R9 all cleared", rv, 32'h0);
    // R8 receive overrun
    send_byte(8'h11);
    wait_cycles(FRAME);
    send_byte(8'h22);
    wait_cycles(FRAME);
    bus_read(5'h04, rv); check("R8 rx overrun", rv, 32'hA);
    bus_read(5'h0C, rv); check("R9 rx overrun flag", rv, 32'hB);
    check("R10 irq_ovr rx", {31'h0, irq_ovr}, 32'h1);
    bus_read(5'h00, rv); check("R8 old byte kept", rv, 32'h11);
    bus_write(5'h04, 32'h8);
    bus_read(5'h04, rv); check("R8 overrun cleared", rv, 32'h0);
    bus_write(5'h0C, 32'hF);
    // R11 receiver disabled
    bus_write(5'h08, 32'h01);
    send_byte(8'h77);
    wait_cycles(FRAME);
    bus_read(5'h04, rv); check("R11 no rx byte", rv, 32'h0);
    bus_read(5'h0C, rv); check("R11 no rx flag", rv, 32'h1);
    bus_write(5'h0C, 32'hF);
    // R7 false start
    bus_write(5'h08, 32'h02);
    loop_en = 1'b0;
    bench_rxd = 1'b0; wait_cycles(DIV / 4); bench_rxd = 1'b1;
    wait_cycles(FRAME + 60);
    bus_read(5'h04, rv); check("R7 glitch rejected", rv, 32'h0);
    bus_read(5'h0C, rv); check("R7 no flag", rv, 32'h0);
    // R6 externally driven frame
    drive_frame(8'hC3);
    wait_cycles(DIV);
    bus_read(5'h04, rv); check("R6 ext full", rv, 32'h2);
    bus_read(5'h00, rv); check("R6 ext data", rv, 32'hC3);
    check("R3 queue drained", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule